// File: doc/BRIEF.md
# Message-Signalled Interrupt File Priority Logic

This block holds the complete state of one interrupt file for one hart. For every interrupt identity it keeps a pending bit and an enable bit. Beside those bits it keeps a one-bit delivery switch and a priority threshold. Identities are set pending by incoming message strobes, where each strobe carries one identity number. Software inspects and changes the state through a read-modify-write register port. Each access returns the current value of the selected register combinationally. In the same access it writes the bits chosen by a write mask, and the write takes effect at the next clock edge.

The block continuously selects the winning identity. The winner is the lowest-numbered identity that is pending, enabled and allowed by the threshold. The interrupt line to the hart rises when delivery is switched on and a winner exists. Software claims the winner through the top register: a read returns the winner's number, and any write clears that identity's pending bit. Address decoding, privilege routing and multiple files sit outside this block.

Register select codes on `acc_kind`:
- 0: delivery switch.
- 1: threshold.
- 2: top/claim.
- 4: pending word.
- 5: enable word.

Any other code reads 0 and ignores writes. For code 4 and code 5, `acc_word` = k covers identities 32k to 32k+31, and bit j of the word is identity 32k+j.

Top module: `msi_prio_file`

## Requirements
- R1: After reset every pending bit, enable bit, the threshold and the delivery switch are zero, the top register reads 0 and `irq_out` is low.
- R2: An identity is a candidate only when its pending and enable bits are both set, and the lowest-numbered candidate wins. The top register reads the winner's number in bits 10:0 and again in bits 26:16. It reads 0 when there is no candidate.
- R3: A nonzero threshold T restricts candidates to identities strictly below T. A threshold of 0 applies no filter.
- R4: `irq_out` is high exactly when delivery bit 0 is set and a candidate exists.
- R5: An access to the top register with a nonzero write mask ignores the write data. It clears the pending bit of the identity that was the winner in that cycle. With no winner it changes nothing.
- R6: Writes are masked, so only bits set in `acc_wmask` change. Only bit 0 of the delivery register is stored, and other bits read 0. The threshold stores only its low $clog2(NUM_IDS+1) bits.
- R7: The pending and enable bits of identity 0 always read 0. A message strobe for identity 0, or for an identity above NUM_IDS, changes no state.
- R8: A message strobe sets its identity's pending bit at the next clock edge. If a claim or a register write clears that same bit in the same cycle, the set wins.
- R9: Pending and enable words with `acc_word` at or beyond (NUM_IDS+1)/32 read 0, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| set_valid | input | 1 | Message strobe, one cycle per message |
| set_id | input | 11 | Identity carried by the message |
| acc_valid | input | 1 | Register access this cycle |
| acc_kind | input | 3 | Register select code |
| acc_word | input | 6 | Word index for pending/enable words |
| acc_wdata | input | 32 | Write data |
| acc_wmask | input | 32 | Write mask; zero makes the access a pure read |
| acc_rdata | output | 32 | Value of the selected register before the access |
| irq_out | output | 1 | External interrupt line to the hart |

## Verification
The assertions assume the following about the inputs:
- `set_id` and `acc_word` may take any value, because the block itself rejects identities and words that are out of range.
- `acc_kind` and `acc_wmask` hold their values for the whole cycle in which `acc_valid` is high.

The claim assertion excuses the one case where a message for the winner arrives in the claim cycle. The stimulus changes inputs only on the falling clock edge and holds each strobe for exactly one cycle. It deliberately produces out-of-range identities and words, masked partial writes, and a claim that coincides with a message for the same identity.

// File: rtl/msi_prio_file.sv
module msi_prio_file #(
  parameter int NUM_IDS = 63
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        set_valid,
  input  logic [10:0] set_id,
  input  logic        acc_valid,
  input  logic [2:0]  acc_kind,
  input  logic [5:0]  acc_word,
  input  logic [31:0] acc_wdata,
  input  logic [31:0] acc_wmask,
  output logic [31:0] acc_rdata,
  output logic        irq_out
);
  localparam int NIDS   = NUM_IDS + 1;
  localparam int IDW    = $clog2(NIDS);
  localparam int NWORDS = NIDS / 32;

  localparam logic [2:0] K_DELIV = 3'd0;
  localparam logic [2:0] K_THR   = 3'd1;
  localparam logic [2:0] K_TOP   = 3'd2;
  localparam logic [2:0] K_PEND  = 3'd4;
  localparam logic [2:0] K_ENAB  = 3'd5;

  logic [NIDS-1:0] pend_q, en_q, pend_n, en_n, elig;
  logic [IDW-1:0]  thr_q, win_id;
  logic            deliv_q;
  logic [31:0]     top_val;

  wire do_write = acc_valid && (acc_wmask != 32'd0);
  wire claim    = do_write && (acc_kind == K_TOP) && (win_id != '0);
  wire set_ok   = set_valid && (set_id != 11'd0) && (set_id <= 11'(NUM_IDS));

  always_comb begin
    elig = '0;
    for (int i = 1; i < NIDS; i++)
      elig[i] = pend_q[i] && en_q[i] && ((thr_q == '0) || (IDW'(i) < thr_q));
  end

  always_comb begin
    win_id = '0;
    for (int i = NUM_IDS; i >= 1; i--)
      if (elig[i]) win_id = IDW'(i);
  end

  assign top_val = 32'(win_id) | (32'(win_id) << 16);
  assign irq_out = deliv_q && (win_id != '0);

  always_comb begin
    pend_n = pend_q;
    en_n   = en_q;
    if (acc_valid) begin
      for (int w = 0; w < NWORDS; w++) begin
        if (acc_word == 6'(w)) begin
          if (acc_kind == K_PEND)
            pend_n[w*32 +: 32] = (pend_q[w*32 +: 32] & ~acc_wmask) | (acc_wdata & acc_wmask);
          if (acc_kind == K_ENAB)
            en_n[w*32 +: 32] = (en_q[w*32 +: 32] & ~acc_wmask) | (acc_wdata & acc_wmask);
        end
      end
    end
    if (claim) pend_n[win_id] = 1'b0;
    if (set_ok) pend_n[set_id[IDW-1:0]] = 1'b1;
    pend_n[0] = 1'b0;
    en_n[0]   = 1'b0;
  end

  always_comb begin
    acc_rdata = 32'd0;
    case (acc_kind)
      K_DELIV: acc_rdata = {31'd0, deliv_q};
      K_THR:   acc_rdata = 32'(thr_q);
      K_TOP:   acc_rdata = top_val;
      K_PEND, K_ENAB: begin
        for (int w = 0; w < NWORDS; w++)
          if (acc_word == 6'(w))
            acc_rdata = (acc_kind == K_PEND) ? pend_q[w*32 +: 32] : en_q[w*32 +: 32];
      end
      default: acc_rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend_q  <= '0;
      en_q    <= '0;
      thr_q   <= '0;
      deliv_q <= 1'b0;
    end else begin
      pend_q <= pend_n;
      en_q   <= en_n;
      if (do_write && acc_kind == K_THR)
        thr_q <= (thr_q & ~acc_wmask[IDW-1:0]) | (acc_wdata[IDW-1:0] & acc_wmask[IDW-1:0]);
      if (do_write && acc_kind == K_DELIV && acc_wmask[0])
        deliv_q <= acc_wdata[0];
    end
  end
endmodule

module msi_prio_file_chk #(
  parameter int NUM_IDS = 63,
  parameter int IDW = $clog2(NUM_IDS + 1)
) (
  input logic             clk,
  input logic             rst_n,
  input logic             set_valid,
  input logic [10:0]      set_id,
  input logic             acc_valid,
  input logic [2:0]       acc_kind,
  input logic [31:0]      acc_wmask,
  input logic             irq_out,
  input logic [NUM_IDS:0] pend_q,
  input logic [NUM_IDS:0] en_q,
  input logic [IDW-1:0]   thr_q,
  input logic             deliv_q,
  input logic [IDW-1:0]   win_id
);
  a_r2_winner_is_candidate: assert property (@(posedge clk) disable iff (!rst_n)
    (win_id != '0) |-> (pend_q[win_id] && en_q[win_id]));

  a_r3_winner_below_threshold: assert property (@(posedge clk) disable iff (!rst_n)
    (thr_q != '0 && win_id != '0) |-> (win_id < thr_q));

  a_r4_irq_needs_delivery: assert property (@(posedge clk) disable iff (!rst_n)
    irq_out |-> (deliv_q && win_id != '0));

  a_r5_claim_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid && acc_kind == 3'd2 && acc_wmask != 32'd0 && win_id != '0 &&
     !(set_valid && set_id == 11'(win_id))) |=> !pend_q[$past(win_id)]);

  a_r7_id0_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !pend_q[0] && !en_q[0]);

  a_r8_set_lands: assert property (@(posedge clk) disable iff (!rst_n)
    (set_valid && set_id != 11'd0 && set_id <= 11'(NUM_IDS)) |=> pend_q[$past(set_id[IDW-1:0])]);
endmodule

bind msi_prio_file msi_prio_file_chk #(.NUM_IDS(NUM_IDS)) chk_i (
  .clk(clk), .rst_n(rst_n), .set_valid(set_valid), .set_id(set_id),
  .acc_valid(acc_valid), .acc_kind(acc_kind), .acc_wmask(acc_wmask),
  .irq_out(irq_out), .pend_q(pend_q), .en_q(en_q), .thr_q(thr_q),
  .deliv_q(deliv_q), .win_id(win_id)
);

// File: tb/msi_prio_file_tb.sv
module msi_prio_file_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic set_valid = 1'b0;
  logic [10:0] set_id = '0;
  logic acc_valid = 1'b0;
  logic [2:0] acc_kind = '0;
  logic [5:0] acc_word = '0;
  logic [31:0] acc_wdata = '0, acc_wmask = '0;
  logic [31:0] acc_rdata;
  logic irq_out;

  int n_checks = 0, n_fails = 0;
  bit finished = 1'b0;

  localparam logic [2:0] DELIV = 3'd0, THR = 3'd1, TOP = 3'd2, PEND = 3'd4, ENAB = 3'd5;

  always #5 clk = ~clk;

  msi_prio_file #(.NUM_IDS(63)) dut_i (
    .clk(clk), .rst_n(rst_n), .set_valid(set_valid), .set_id(set_id),
    .acc_valid(acc_valid), .acc_kind(acc_kind), .acc_word(acc_word),
    .acc_wdata(acc_wdata), .acc_wmask(acc_wmask), .acc_rdata(acc_rdata),
    .irq_out(irq_out)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", req, act, exp);
    end
  endtask

  task automatic acc(input logic [2:0] k, input logic [5:0] w, input logic [31:0] d, input logic [31:0] m);
    @(negedge clk);
    acc_valid = 1'b1; acc_kind = k; acc_word = w; acc_wdata = d; acc_wmask = m;
    @(negedge clk);
    acc_valid = 1'b0; acc_wmask = '0;
  endtask

  task automatic rd(input logic [2:0] k, input logic [5:0] w, output logic [31:0] v);
    @(negedge clk);
    acc_valid = 1'b1; acc_kind = k; acc_word = w; acc_wmask = '0;
    #1 v = acc_rdata;
    @(negedge clk);
    acc_valid = 1'b0;
  endtask

  task automatic msg(input logic [10:0] id);
    @(negedge clk);
    set_valid = 1'b1; set_id = id;
    @(negedge clk);
    set_valid = 1'b0;
  endtask

  task automatic t_reset();
    logic [31:0] v;
    rd(TOP, 0, v);   check("R1 top", v, 32'h0);
    check("R1 irq", {31'd0, irq_out}, 32'h0);
    rd(DELIV, 0, v); check("R1 delivery", v, 32'h0);
    rd(PEND, 0, v);  check("R1 pending", v, 32'h0);
  endtask

  task automatic t_basic();
    logic [31:0] v;
    acc(ENAB, 0, 32'h220, 32'h220);
    msg(11'd9);
    rd(TOP, 0, v); check("R2 single winner 9", v, 32'h0009_0009);
    msg(11'd5);
    rd(TOP, 0, v); check("R2 lower id wins", v, 32'h0005_0005);
    msg(11'd3);
    rd(TOP, 0, v); check("R2 pending but disabled ignored", v, 32'h0005_0005);
    check("R4 irq low without delivery", {31'd0, irq_out}, 32'h0);
    acc(DELIV, 0, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    rd(DELIV, 0, v); check("R6 delivery only bit0", v, 32'h1);
    check("R4 irq high", {31'd0, irq_out}, 32'h1);
    acc(DELIV, 0, 32'h0, 32'hFFFF_FFFE);
    rd(DELIV, 0, v); check("R6 masked delivery write", v, 32'h1);
  endtask

  task automatic t_thresh();
    logic [31:0] v;
    acc(THR, 0, 32'd5, 32'hFFFF_FFFF);
    rd(TOP, 0, v); check("R3 threshold 5 excludes 5", v, 32'h0);
    check("R4 irq low when filtered", {31'd0, irq_out}, 32'h0);
    acc(THR, 0, 32'd6, 32'hFFFF_FFFF);
    rd(TOP, 0, v); check("R3 threshold 6 admits 5", v, 32'h0005_0005);
    acc(THR, 0, 32'hFFFF, 32'hFFFF_FFFF);
    rd(THR, 0, v); check("R6 threshold width mask", v, 32'h3F);
    acc(THR, 0, 32'd0, 32'hFFFF_FFFF);
    rd(TOP, 0, v); check("R3 threshold zero no filter", v, 32'h0005_0005);
    check("R4 irq high again", {31'd0, irq_out}, 32'h1);
  endtask

  task automatic t_claim();
    logic [31:0] v;
    acc(TOP, 0, 32'h0, 32'hFFFF_FFFF);
    rd(TOP, 0, v); check("R5 claim clears 5", v, 32'h0009_0009);
    acc(TOP, 0, 32'h5, 32'hFFFF_FFFF);
    rd(TOP, 0, v); check("R5 claim clears 9", v, 32'h0);
    rd(PEND, 0, v); check("R5 only winners cleared", v, 32'h8);
    check("R4 irq low no candidate", {31'd0, irq_out}, 32'h0);
    acc(TOP, 0, 32'h0, 32'hFFFF_FFFF);
    rd(PEND, 0, v); check("R5 claim without winner", v, 32'h8);
  endtask

  task automatic t_id0();
    logic [31:0] v;
    acc(PEND, 0, 32'hFFFF_FFFF, 32'h1);
    rd(PEND, 0, v); check("R7 pending bit0 read-only", v, 32'h8);
    msg(11'd0);
    msg(11'd64);
    rd(PEND, 0, v); check("R7 id 0 message ignored", v, 32'h8);
    rd(PEND, 1, v); check("R7 id above range ignored", v, 32'h0);
    acc(ENAB, 0, 32'h1, 32'h1);
    rd(ENAB, 0, v); check("R7 enable bit0 read-only", v, 32'h220);
  endtask

  task automatic t_words();
    logic [31:0] v;
    acc(ENAB, 1, 32'h100, 32'h100);
    msg(11'd40);
    rd(PEND, 1, v); check("R8 message sets pending", v, 32'h100);
    rd(TOP, 0, v); check("R2 winner in word 1", v, 32'h0028_0028);
    acc(ENAB, 2, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    rd(ENAB, 2, v); check("R9 out-of-range word reads 0", v, 32'h0);
    rd(TOP, 0, v); check("R9 out-of-range write no effect", v, 32'h0028_0028);
  endtask

  task automatic t_race();
    logic [31:0] v;
    @(negedge clk);
    acc_valid = 1'b1; acc_kind = TOP; acc_word = '0; acc_wdata = '0; acc_wmask = 32'hFFFF_FFFF;
    set_valid = 1'b1; set_id = 11'd40;
    @(negedge clk);
    acc_valid = 1'b0; acc_wmask = '0; set_valid = 1'b0;
    rd(TOP, 0, v); check("R8 set wins over claim", v, 32'h0028_0028);
    acc(PEND, 1, 32'h0, 32'h100);
    rd(TOP, 0, v); check("R6 masked pending clear", v, 32'h0);
    rd(PEND, 1, v); check("R6 pending word after clear", v, 32'h0);
  endtask

  task automatic summary();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_basic();
    t_thresh();
    t_claim();
    t_id0();
    t_words();
    t_race();
    repeat (2) @(negedge clk);
    summary();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      summary();
    end
  end
endmodule